// File: doc/BRIEF.md
# Interleaved DRAM Slot Timing Generator

This block runs off one system clock and carves time into a repeating basic cycle of 16 clocks. The cycle holds four memory slots of four clocks each. Slots 0, 1 and 2 always belong to the processor. Slot 3 is the display slot. The generator drives a processor clock, a memory-slot phase, a pair of lead phases and a strobe that advances the display address counters. It also drives one grant line for each requester, so that DRAM sequencing logic elsewhere can tell whose fetch runs in the current slot.

Slot 3 is given to an owner once per basic cycle, using three level inputs from the display timing counter. During active display the slot fetches video. During horizontal or vertical retrace the processor gets it. The final basic cycle of each line (`line_end`) reserves it for the sound and disk-speed fetch, whatever the retrace state.

Top module: `slot_timing_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `slot_idx` = 0, `cpu_clk`, `mem_ph`, `lead_hi`, `lead_lo` and `vid_step` all 0, and all three grants deasserted. Counting restarts from position 0 after release.
- R2: `cpu_clk` is bit 0 of a 4-bit position count that advances by one per clock. It therefore toggles on every clock.
- R3: `mem_ph` is bit 1 of the position count. It toggles every second clock, giving a period of 4 clocks.
- R4: `slot_idx` is bits 3:2 of the position count. Each value lasts 4 clocks, the values run 0,1,2,3 and wrap to 0, and the basic cycle is 16 clocks.
- R5: {`lead_hi`,`lead_lo`} equals bits 3:2 of (position + 3) mod 16. Both are high from 3 clocks before slot 3 until 3 clocks before slot 3 ends.
- R6: `vid_step` is high for exactly one clock per basic cycle, at position 13. That is the second clock of slot 3, the clock in which `lead_lo` has just fallen.
- R7: In slots 0, 1 and 2, only `gnt_cpu` is asserted.
- R8: Slot 3 grants `gnt_vid` when `h_retrace`, `v_retrace` and `line_end` were all low at the decision point.
- R9: Slot 3 grants `gnt_cpu` when `h_retrace` was high and `line_end` low at the decision point.
- R10: Slot 3 grants `gnt_snd` whenever `line_end` was high at the decision point, in any retrace state.
- R11: During vertical retrace (`v_retrace` high), slot 3 grants `gnt_cpu` unless `line_end` was high.
- R12: The decision point is the clock edge that ends position 11. Input changes during slot 3 do not alter its grant. Exactly one grant is high in every cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| h_retrace | input | 1 | Horizontal retrace in progress |
| v_retrace | input | 1 | Vertical retrace in progress |
| line_end | input | 1 | Current basic cycle is the last of a line |
| cpu_clk | output | 1 | Processor clock, system clock divided by 2 |
| mem_ph | output | 1 | Memory slot phase, processor clock divided by 2 |
| lead_hi | output | 1 | Upper lead phase, 3 clocks ahead of the slot index |
| lead_lo | output | 1 | Lower lead phase, 3 clocks ahead of the slot index |
| vid_step | output | 1 | One-clock strobe advancing the display counters |
| slot_idx | output | 2 | Current memory slot, 0 to 3 |
| gnt_cpu | output | 1 | Processor owns the current slot |
| gnt_vid | output | 1 | Video fetch owns the current slot |
| gnt_snd | output | 1 | Sound/disk-speed fetch owns the current slot |

## Verification
The ownership assertions assume that the retrace and line-end levels are settled at the edge closing position 11. They also assume that only the value seen there matters for slot 3. The bench drives those inputs on falling edges at position 11, then inverts all three during slot 3 to show that the grant holds. Reset is applied at time zero and again partway through a basic cycle, and the assertions are disabled while it is high.

// File: rtl/slot_timing_pkg.sv
package slot_timing_pkg;

    typedef enum logic [1:0] {
        OWN_CPU = 2'd0,
        OWN_VID = 2'd1,
        OWN_SND = 2'd2
    } owner_e;

    typedef struct packed {
        logic cpu;
        logic vid;
        logic snd;
    } grant_t;

    typedef struct packed {
        logic cpu_clk;
        logic mem_ph;
        logic lead_hi;
        logic lead_lo;
        logic vid_step;
    } phase_t;

    // Owner of the display slot: line end wins, then any retrace, else video.
    function automatic owner_e pick_owner(input logic hr, input logic vr, input logic le);
        if (le)
            return OWN_SND;
        else if (hr || vr)
            return OWN_CPU;
        else
            return OWN_VID;
    endfunction

    function automatic grant_t owner_to_grant(input owner_e o);
        grant_t g;
        g = '0;
        case (o)
            OWN_VID: g.vid = 1'b1;
            OWN_SND: g.snd = 1'b1;
            default: g.cpu = 1'b1;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/st_phase_counter.sv
module st_phase_counter
    import slot_timing_pkg::*;
#(
    parameter int PHASE_W   = 4,
    parameter int LEAD_CLKS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic [PHASE_W-1:0]   cnt_q,
    output logic [PHASE_W-1:0]   cnt_nx,
    output phase_t               ph,
    output logic [PHASE_W-3:0]   slot
);
    localparam int SLOT_W   = PHASE_W - 2;
    localparam int FRAME    = 1 << PHASE_W;
    localparam int SLOT_LEN = FRAME >> SLOT_W;
    localparam int VID_SLOT = (1 << SLOT_W) - 1;
    localparam int STEP_POS = VID_SLOT * SLOT_LEN + 1;

    logic [PHASE_W-1:0] lead;

    assign cnt_nx = cnt_q + PHASE_W'(1);
    assign lead   = cnt_q + PHASE_W'(LEAD_CLKS);

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else
            cnt_q <= cnt_nx;
    end

    always_comb begin
        ph.cpu_clk  = cnt_q[0];
        ph.mem_ph   = cnt_q[1];
        ph.lead_hi  = lead[PHASE_W-1];
        ph.lead_lo  = lead[PHASE_W-2];
        ph.vid_step = (cnt_q == PHASE_W'(STEP_POS));
    end

    assign slot = cnt_q[PHASE_W-1 -: SLOT_W];

    assert_cpu_clk_toggle_R2: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ph.cpu_clk != $past(ph.cpu_clk)));

    assert_mem_ph_period_R3: assert property (@(posedge clk) disable iff (rst)
        (ph.cpu_clk && !$past(rst)) |=> (ph.mem_ph != $past(ph.mem_ph)));

    assert_slot_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_W'(VID_SLOT) && ph.mem_ph && ph.cpu_clk) |=> (slot == '0));

    assert_lead_before_video_R5: assert property (@(posedge clk) disable iff (rst)
        (ph.lead_hi && ph.lead_lo) |-> (slot != '0));

    assert_vid_step_edge_R6: assert property (@(posedge clk) disable iff (rst)
        ph.vid_step |-> ($fell(ph.lead_lo) && slot == SLOT_W'(VID_SLOT)));

endmodule

// File: rtl/st_slot_arbiter.sv
module st_slot_arbiter
    import slot_timing_pkg::*;
#(
    parameter int PHASE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] cnt_q,
    input  logic [PHASE_W-1:0] cnt_nx,
    input  logic               h_retrace,
    input  logic               v_retrace,
    input  logic               line_end,
    output grant_t             gnt
);
    localparam int SLOT_W   = PHASE_W - 2;
    localparam int FRAME    = 1 << PHASE_W;
    localparam int SLOT_LEN = FRAME >> SLOT_W;
    localparam int VID_SLOT = (1 << SLOT_W) - 1;
    localparam int DECIDE   = VID_SLOT * SLOT_LEN - 1;

    owner_e             owner_q;
    owner_e             owner_now;
    logic               decide;
    logic [SLOT_W-1:0]  slot_nx;
    grant_t             gnt_nx;

    assign decide    = (cnt_q == PHASE_W'(DECIDE));
    assign owner_now = decide ? pick_owner(h_retrace, v_retrace, line_end) : owner_q;
    assign slot_nx   = cnt_nx[PHASE_W-1 -: SLOT_W];

    always_comb begin
        if (slot_nx == SLOT_W'(VID_SLOT))
            gnt_nx = owner_to_grant(owner_now);
        else
            gnt_nx = owner_to_grant(OWN_CPU);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            owner_q <= OWN_CPU;
            gnt     <= '0;
        end else begin
            if (decide)
                owner_q <= owner_now;
            gnt <= gnt_nx;
        end
    end

    assert_low_slots_cpu_R7: assert property (@(posedge clk) disable iff (rst)
        (gnt.vid || gnt.snd) |-> (cnt_q[PHASE_W-1 -: SLOT_W] == SLOT_W'(VID_SLOT)));

    assert_video_active_R8: assert property (@(posedge clk) disable iff (rst)
        (decide && !h_retrace && !v_retrace && !line_end) |=> gnt.vid);

    assert_hretrace_cpu_R9: assert property (@(posedge clk) disable iff (rst)
        (decide && h_retrace && !line_end) |=> gnt.cpu);

    assert_sound_slot_R10: assert property (@(posedge clk) disable iff (rst)
        (decide && line_end) |=> gnt.snd);

    assert_vretrace_cpu_R11: assert property (@(posedge clk) disable iff (rst)
        (decide && v_retrace && !line_end) |=> gnt.cpu);

    assert_one_grant_R12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ($countones(gnt) == 1));

    assert_grant_held_R12: assert property (@(posedge clk) disable iff (rst)
        (cnt_q[PHASE_W-1 -: SLOT_W] == SLOT_W'(VID_SLOT) && cnt_q[1:0] != 2'b11)
        |=> $stable(gnt));

endmodule

// File: rtl/slot_timing_gen.sv
module slot_timing_gen
    import slot_timing_pkg::*;
#(
    parameter int PHASE_W   = 4,
    parameter int LEAD_CLKS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_retrace,
    input  logic               v_retrace,
    input  logic               line_end,
    output logic               cpu_clk,
    output logic               mem_ph,
    output logic               lead_hi,
    output logic               lead_lo,
    output logic               vid_step,
    output logic [PHASE_W-3:0] slot_idx,
    output logic               gnt_cpu,
    output logic               gnt_vid,
    output logic               gnt_snd
);
    logic [PHASE_W-1:0] cnt_q;
    logic [PHASE_W-1:0] cnt_nx;
    phase_t             ph;
    grant_t             gnt;

    st_phase_counter #(
        .PHASE_W   (PHASE_W),
        .LEAD_CLKS (LEAD_CLKS)
    ) u_phase (
        .clk    (clk),
        .rst    (rst),
        .cnt_q  (cnt_q),
        .cnt_nx (cnt_nx),
        .ph     (ph),
        .slot   (slot_idx)
    );

    st_slot_arbiter #(
        .PHASE_W (PHASE_W)
    ) u_arb (
        .clk       (clk),
        .rst       (rst),
        .cnt_q     (cnt_q),
        .cnt_nx    (cnt_nx),
        .h_retrace (h_retrace),
        .v_retrace (v_retrace),
        .line_end  (line_end),
        .gnt       (gnt)
    );

    assign cpu_clk  = ph.cpu_clk;
    assign mem_ph   = ph.mem_ph;
    assign lead_hi  = ph.lead_hi;
    assign lead_lo  = ph.lead_lo;
    assign vid_step = ph.vid_step;
    assign gnt_cpu  = gnt.cpu;
    assign gnt_vid  = gnt.vid;
    assign gnt_snd  = gnt.snd;

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (slot_idx == '0 && !gnt_cpu && !gnt_vid && !gnt_snd && !vid_step));

endmodule

// File: tb/tb_slot_timing_gen.sv
module tb_slot_timing_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       h_retrace = 1'b0;
    logic       v_retrace = 1'b0;
    logic       line_end = 1'b0;
    logic       cpu_clk, mem_ph, lead_hi, lead_lo, vid_step;
    logic [1:0] slot_idx;
    logic       gnt_cpu, gnt_vid, gnt_snd;

    int checks = 0;
    int errors = 0;
    int ecnt = 0;
    logic in_rst = 1'b1;
    logic [2:0] exp_own = 3'b010;   // {cpu,vid,snd} for slot 3
    string slot3_tag = "R8";
    bit done = 0;

    always #5 clk = ~clk;

    slot_timing_gen dut (
        .clk(clk), .rst(rst), .h_retrace(h_retrace), .v_retrace(v_retrace),
        .line_end(line_end), .cpu_clk(cpu_clk), .mem_ph(mem_ph),
        .lead_hi(lead_hi), .lead_lo(lead_lo), .vid_step(vid_step),
        .slot_idx(slot_idx), .gnt_cpu(gnt_cpu), .gnt_vid(gnt_vid), .gnt_snd(gnt_snd)
    );

    // {h_retrace, v_retrace, line_end, expected {cpu,vid,snd}}
    localparam logic [5:0] VEC [0:7] = '{
        6'b000_010, 6'b100_100, 6'b101_001, 6'b010_100,
        6'b011_001, 6'b110_100, 6'b001_001, 6'b000_010
    };

    function automatic string tag_for(input logic [5:0] v);
        if (v[3]) return "R10";
        if (v[4]) return "R11";
        if (v[5]) return "R9";
        return "R8";
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s pos=%0d actual=%b expected=%b", tag, ecnt, act, exp);
        end
    endtask

    task automatic check_all(input string g3_tag);
        logic [3:0] lead;
        logic [2:0] eg;
        string t;
        lead = 4'(ecnt + 3);
        if (in_rst) begin
            check("R1 reset", {1'b0, cpu_clk, mem_ph, lead_hi, lead_lo, vid_step, slot_idx},
                  8'b0);
            check("R1 grants", {5'b0, gnt_cpu, gnt_vid, gnt_snd}, 8'b0);
        end else begin
            check("R2 R3 R4 R5 R6 phases",
                  {1'b0, cpu_clk, mem_ph, lead_hi, lead_lo, vid_step, slot_idx},
                  {1'b0, ecnt[0] == 1, ecnt[1] == 1, lead[3], lead[2], ecnt == 13, 2'(ecnt >> 2)});
            if ((ecnt >> 2) == 3) begin
                eg = exp_own;
                t  = g3_tag;
            end else begin
                eg = 3'b100;
                t  = "R7";
            end
            check(t, {5'b0, gnt_cpu, gnt_vid, gnt_snd}, {5'b0, eg});
        end
    endtask

    task automatic step(input string g3_tag);
        @(posedge clk);
        in_rst = rst;
        if (rst) ecnt = 0;
        else ecnt = (ecnt + 1) % 16;
        @(negedge clk);
        check_all(g3_tag);
    endtask

    initial begin
        @(negedge clk);
        check_all("R1");
        step("R1");
        step("R1");
        rst = 1'b0;
        // first basic cycle with active display inputs
        for (int i = 0; i < 16; i++) step("R8");

        // walk the ownership vectors
        for (int v = 0; v < 8; v++) begin
            while (ecnt != 11) step("R12");
            h_retrace = VEC[v][5];
            v_retrace = VEC[v][4];
            line_end  = VEC[v][3];
            exp_own   = VEC[v][2:0];
            slot3_tag = tag_for(VEC[v]);
            step(slot3_tag);
            // invert inputs inside slot 3: grant must hold (R12)
            h_retrace = ~h_retrace;
            v_retrace = ~v_retrace;
            line_end  = ~line_end;
            step("R12");
            step("R12");
            step("R12");
        end

        // reset in the middle of a basic cycle (R1), then restart from 0
        while (ecnt != 6) step("R12");
        rst = 1'b1;
        step("R1");
        step("R1");
        rst = 1'b0;
        h_retrace = 1'b0; v_retrace = 1'b0; line_end = 1'b0;
        exp_own = 3'b010;
        for (int i = 0; i < 20; i++) step("R8");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule